// File: doc/BRIEF.md
# Delay-Interpolated Square-Wave Synthesiser

This block generates a programmable square-wave clock without a waveform table or a converter. A phase accumulator adds a tuning word on every reference cycle. The output level toggles each time the accumulator wraps, so the output runs at half the wrap rate. With a 24-bit accumulator and a 67.108864 MHz reference, one tuning-word step is 2 Hz at the output.

The block also emits a strobe on each wrap. The value left in the accumulator after the wrap is divided by the active tuning word. That ratio is the fraction of a reference period by which the edge must be shifted. It is quantised into steps of about 130 ps, 114 of them per reference period. The result is a select code for three cascaded programmable delay stages, coarsest first, which sit outside this block and place the final edge.

The highest output frequency is 15 MHz, and larger tuning words are clamped to that limit. A tuning word of zero leaves the output static. To avoid runt pulses, a tuning word change takes effect only at a wrap.

Top module: `dds_edge_gen`

## Requirements
- R1: While reset is asserted and after it is released, `edge_stb`, `out_lvl` and `dly_code` are all 0, and the active tuning word is zero.
- R2: On each clock with `en` high and a nonzero active tuning word T, T is added modulo 2^24. If the addition overflows, `edge_stb` is high for exactly the following cycle. Otherwise it is low.
- R3: `out_lvl` inverts in exactly the cycles in which `edge_stb` is high, and holds in all other cycles.
- R4: With each strobe, `dly_code` equals floor(r·114/T), where r is the accumulator value after the wrap and T is the tuning word in use before the wrap. The code is always below 114.
- R5: `dly_code` is 9 bits wide and drives three 3-bit delay-stage selects. Bits [8:6] drive the first (coarsest) stage, bits [5:3] the middle stage and bits [2:0] the finest stage.
- R6: While the active tuning word is zero, no strobe is produced and `out_lvl` stays constant.
- R7: A tuning word above 7,500,000 (15 MHz) is used as 7,500,000.
- R8: A nonzero active tuning word is replaced by `tune_word` only on a wrap. While the active word is zero, `tune_word` is taken on the next enabled clock.
- R9: While `en` is low, the accumulator, the active tuning word, `out_lvl` and `dly_code` hold their values and `edge_stb` is low.
- R10: `dly_code` changes only in cycles in which `edge_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable; low freezes the block |
| tune_word | input | 24 | Requested frequency in 2 Hz units |
| edge_stb | output | 1 | One-cycle pulse marking a coarse output edge |
| dly_code | output | 9 | Three-stage delay select, coarsest stage in the top bits |
| out_lvl | output | 1 | Current square-wave level |

## Verification
The bench goes after the residue arithmetic with tuning words that leave nonzero remainders at each wrap. A worked case gives the codes 38, 76 and 0 in turn. A design with a wrong divisor or a misordered field split would show the wrong stage selects there. A tuning word is changed mid-period, and the bench checks that the old spacing continues until the next wrap. A design that loads the new word at once would shift the edge early and produce a runt. The bench also drives an oversized tuning word and expects a strobe roughly every 2.24 cycles. Without clamping, the design would strobe on every cycle. The zero-word and enable-low phases confirm that nothing moves. A block that keeps accumulating would toggle the output or alter the code.

// File: rtl/dds_pkg.sv
package dds_pkg;
    // Number of cascaded delay stages fed by the select code
    localparam int DDS_STAGES = 3;
endpackage

// File: rtl/dds_tw_limit.sv
module dds_tw_limit #(
    parameter int TW_W   = 24,
    parameter int TW_MAX = 7500000
) (
    input  logic [TW_W-1:0] tw_in,
    output logic [TW_W-1:0] tw_out
);
    localparam logic [TW_W-1:0] LIMIT = TW_W'(TW_MAX);

    always_comb begin
        if (tw_in > LIMIT) tw_out = LIMIT;
        else               tw_out = tw_in;
    end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic [ACC_W-1:0] acc_cur,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             wrap
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc_cur} + {1'b0, step};
        acc_nxt = sum[ACC_W-1:0];
        wrap    = sum[ACC_W];
    end
endmodule

// File: rtl/dds_residue_quant.sv
module dds_residue_quant
    import dds_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int NUM_STEPS = 114,
    parameter int SEL_W     = 3
) (
    input  logic [ACC_W-1:0]                residue,
    input  logic [ACC_W-1:0]                tw,
    output logic [DDS_STAGES-1:0][SEL_W-1:0] stage_sel
);
    localparam int CODE_W = DDS_STAGES * SEL_W;
    localparam int NUM_W  = ACC_W + CODE_W;

    logic [NUM_W-1:0]  rem;
    logic [NUM_W-1:0]  trial;
    logic [CODE_W-1:0] quo;

    // Restoring long division: residue < tw and NUM_STEPS <= 2^CODE_W,
    // so the quotient fits in CODE_W bits.
    always_comb begin
        rem = NUM_W'(residue) * NUM_W'(NUM_STEPS);
        quo = '0;
        for (int i = CODE_W - 1; i >= 0; i--) begin
            trial = NUM_W'(tw) << i;
            if (tw != '0 && rem >= trial) begin
                rem    = rem - trial;
                quo[i] = 1'b1;
            end
        end
    end

    // Coarsest stage takes the most significant field.
    for (genvar s = 0; s < DDS_STAGES; s++) begin : g_stage
        assign stage_sel[s] = quo[s*SEL_W +: SEL_W];
    end
endmodule

// File: rtl/dds_edge_gen.sv
module dds_edge_gen
    import dds_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int TW_MAX    = 7500000,
    parameter int NUM_STEPS = 114,
    parameter int SEL_W     = 3,
    localparam int CODE_W   = DDS_STAGES * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ACC_W-1:0]  tune_word,
    output logic              edge_stb,
    output logic [CODE_W-1:0] dly_code,
    output logic              out_lvl
);
    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  tw;
        logic              lvl;
        logic              stb;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t st_d, st_q;

    logic [ACC_W-1:0]                 tw_lim;
    logic [ACC_W-1:0]                 acc_nxt;
    logic                             wrap;
    logic [DDS_STAGES-1:0][SEL_W-1:0] stage_sel;
    logic [ACC_W-1:0]                 tw_act;

    dds_tw_limit #(.TW_W(ACC_W), .TW_MAX(TW_MAX)) u_limit (
        .tw_in  (tune_word),
        .tw_out (tw_lim)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .acc_cur (st_q.acc),
        .step    (st_q.tw),
        .acc_nxt (acc_nxt),
        .wrap    (wrap)
    );

    dds_residue_quant #(.ACC_W(ACC_W), .NUM_STEPS(NUM_STEPS), .SEL_W(SEL_W)) u_quant (
        .residue   (acc_nxt),
        .tw        (st_q.tw),
        .stage_sel (stage_sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (en) begin
            if (st_q.tw == '0) begin
                st_d.tw = tw_lim;
            end else begin
                st_d.acc = acc_nxt;
                if (wrap) begin
                    st_d.stb  = 1'b1;
                    st_d.lvl  = ~st_q.lvl;
                    st_d.code = stage_sel;
                    st_d.tw   = tw_lim;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_stb = st_q.stb;
    assign dly_code = st_q.code;
    assign out_lvl  = st_q.lvl;
    assign tw_act   = st_q.tw;
endmodule

// File: rtl/dds_edge_gen_chk.sv
module dds_edge_gen_chk #(
    parameter int ACC_W     = 24,
    parameter int TW_MAX    = 7500000,
    parameter int NUM_STEPS = 114,
    parameter int CODE_W    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              edge_stb,
    input logic [CODE_W-1:0] dly_code,
    input logic              out_lvl,
    input logic [ACC_W-1:0]  tw_act
);
    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |=> !edge_stb);

    // R3
    lvl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |-> (out_lvl != $past(out_lvl)));

    // R3
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_stb |-> $stable(out_lvl));

    // R4
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_code < CODE_W'(NUM_STEPS));

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_stb |-> $stable(dly_code));

    // R9
    en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !edge_stb);

    // R6
    zero_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_act == '0) |=> !edge_stb);

    // R7
    word_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_act <= ACC_W'(TW_MAX));
endmodule

bind dds_edge_gen dds_edge_gen_chk #(
    .ACC_W(ACC_W), .TW_MAX(TW_MAX), .NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .edge_stb(edge_stb),
    .dly_code(dly_code), .out_lvl(out_lvl), .tw_act(tw_act)
);

// File: tb/dds_edge_gen_bench.sv
module dds_edge_gen_bench;
    localparam int  ACC_W   = 24;
    localparam int  CODE_W  = 9;
    localparam longint MOD  = 64'd1 << ACC_W;
    localparam longint LIM  = 7500000;
    localparam longint STEPS = 114;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [ACC_W-1:0]  tune_word = '0;
    logic              edge_stb;
    logic [CODE_W-1:0] dly_code;
    logic              out_lvl;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dds_edge_gen u_dds_edge_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .tune_word(tune_word),
        .edge_stb(edge_stb), .dly_code(dly_code), .out_lvl(out_lvl)
    );

    // Expected behaviour derived from the requirements
    longint m_acc, m_tw, m_code, m_sum;
    logic   m_stb, m_lvl;

    function automatic longint lim_word(input longint w);
        return (w > LIM) ? LIM : w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_tw = 0; m_code = 0; m_stb = 0; m_lvl = 0;
        end else begin
            m_stb = 0;
            if (en) begin
                if (m_tw == 0) begin
                    m_tw = lim_word(longint'(tune_word));
                end else begin
                    m_sum = m_acc + m_tw;
                    if (m_sum >= MOD) begin
                        m_acc  = m_sum - MOD;
                        m_code = (m_acc * STEPS) / m_tw;
                        m_stb  = 1;
                        m_lvl  = ~m_lvl;
                        m_tw   = lim_word(longint'(tune_word));
                    end else begin
                        m_acc = m_sum;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the expectation for n cycles
    task automatic track(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({req, " strobe"}, longint'(edge_stb), longint'(m_stb));
            check({req, " level"},  longint'(out_lvl),  longint'(m_lvl));
            check({req, " code"},   longint'(dly_code), m_code);
        end
    endtask

    task automatic wait_stb();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (edge_stb) return;
        end
        check("R2 strobe expected", 0, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 strobe after reset", longint'(edge_stb), 0);
        check("R1 level after reset",  longint'(out_lvl),  0);
        check("R1 code after reset",   longint'(dly_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 level held", longint'(out_lvl), 0);
    endtask

    task automatic t_zero_word();
        int stb_seen = 0;
        logic lvl0 = out_lvl;
        en = 1'b1; tune_word = '0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            stb_seen += int'(edge_stb);
            if (out_lvl != lvl0) stb_seen += 100;
        end
        check("R6 no activity with zero word", stb_seen, 0);
    endtask

    task automatic t_fields();
        // T = 6291456: residues 2^21, 2^22, 0 give codes 38, 76, 0
        tune_word = 24'd6291456;
        wait_stb();
        check("R4 first code", longint'(dly_code), 38);
        check("R5 coarse stage [8:6]", longint'(dly_code[8:6]), 0);
        check("R5 middle stage [5:3]", longint'(dly_code[5:3]), 4);
        check("R5 fine stage [2:0]",   longint'(dly_code[2:0]), 6);
        wait_stb();
        check("R4 second code", longint'(dly_code), 76);
        check("R5 coarse stage of 76", longint'(dly_code[8:6]), 1);
        wait_stb();
        check("R4 third code", longint'(dly_code), 0);
        track("R4 R10 fields run", 20);
    endtask

    task automatic t_words();
        tune_word = 24'd4194304;  track("R2 R3 quarter word", 60);
        tune_word = 24'd1000003;  track("R4 R10 odd word", 120);
        tune_word = 24'd7000001;  track("R2 R4 fast word", 80);
    endtask

    task automatic t_clamp();
        int n = 0;
        tune_word = 24'hFFFFFF;
        track("R7 clamp settle", 20);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n += int'(edge_stb);
        end
        // 200 * 7.5e6 / 2^24 = 89.4 strobes; unclamped would give about 200
        checks++;
        if (n < 85 || n > 95) begin
            fails++;
            $display("FAIL R7 strobe count: actual %0d expected 85..95", n);
        end
        track("R7 clamp tracking", 40);
    endtask

    task automatic t_change();
        int gap = 0;
        tune_word = 24'd2097152;            // wrap every 8 cycles
        wait_stb(); wait_stb();
        repeat (2) @(negedge clk);          // mid-period
        tune_word = 24'd4194304;            // would wrap every 4
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            gap++;
            if (edge_stb) break;
        end
        check("R8 old spacing kept until wrap", gap, 6);
        track("R8 after change", 40);
    endtask

    task automatic t_enable();
        logic lvl0;
        logic [CODE_W-1:0] code0;
        int stb_seen = 0;
        tune_word = 24'd5000000;
        track("R9 before pause", 10);
        en = 1'b0;
        @(negedge clk);
        lvl0 = out_lvl; code0 = dly_code;
        tune_word = 24'd1234567;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            stb_seen += int'(edge_stb);
            if (out_lvl != lvl0 || dly_code != code0) stb_seen += 100;
        end
        check("R9 frozen while disabled", stb_seen, 0);
        en = 1'b1;
        track("R9 R8 resume", 60);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_zero_word();
        t_fields();
        t_words();
        t_clamp();
        t_change();
        t_enable();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule